// File: doc/BRIEF.md
# Serial TDM Time Slot Interchange Switch

This block moves bytes between channels of time-division-multiplexed serial lines. Eight receive lines and eight transmit lines each carry a frame of 32 byte-wide channels. Every bit lasts two clock cycles, so a frame lasts 512 cycles. A frame pulse aligns an internal position counter. Each receive line is deserialized, and every finished byte is stored in a data memory at a slot indexed by line and channel.

For every output line and channel, a connection table names the source line and channel. Each cycle, a per-line multiplexer fetches the selected stored byte and drives the current bit, MSB first. The data memory has two banks that swap at every frame boundary. Bytes gathered in one frame are therefore played out in the next, whatever the slot ordering. A host loads the connection table through a small register port, with a page register that selects the output line.

The serial lines are fixed-rate TDM lines, so they carry no valid/ready handshake. Data can never be held back: a receive bit is taken on its sampling cycle whether or not anything downstream is ready, and a transmit bit is driven on its schedule. Pad three-state control is left to the pad ring through a drive flag.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held and right after it, `tx_drv` is 0 and `tx_ser` is all zero. The page register reads back 0, and every connection entry reads back 0.
- R2: Before the first frame pulse after reset, `tx_drv` stays 0 even when `ode` is 1.
- R3: In the cycle after a cycle with `frm_pulse` high, the counter sits on the first cycle of the MSB of channel 0. Each bit spans two cycles, and with no further pulse the counter wraps every 512 cycles. Output drive starts after the first pulse when `ode` is 1.
- R4: Each receive line is sampled on the second cycle of each bit, MSB first. The byte of line s, channel c is stored at slot s*32+c.
- R5: A byte received in frame N appears on the outputs only during frame N+1.
- R6: A connection entry holds the source line in bits [7:5] and the source channel in bits [4:0]. During output channel c of line p, `tx_ser[p]` carries the byte stored at the source slot named by entry (p,c), MSB first, two cycles per bit.
- R7: For a host write with `host_addr[5]`=1, bits [2:0] of the data set the page register (the output line). With `host_addr[5]`=0, the write sets the entry of the paged line at channel `host_addr[4:0]`. `host_rdata` returns the addressed item combinationally.
- R8: With `ode` at 0, `tx_drv` is 0 and `tx_ser` is all zero. Setting `ode` back to 1 resumes output at once, and input storage is unaffected.
- R9: Several output channels may name the same source slot, and each of them carries that byte.
- R10: A frame pulse in mid-frame restarts the counter at channel 0 and swaps the banks. The following full frames line up on the new boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two cycles per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| frm_pulse | input | 1 | Frame alignment pulse, one cycle |
| ode | input | 1 | Output drive enable |
| rx_ser | input | 8 | Serial receive lines |
| tx_ser | output | 8 | Serial transmit data, zero when not driving |
| tx_drv | output | 1 | Drive flag for the transmit pads |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 6 | Host address: bit 5 selects the page register |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |

## Verification
The bench aims at the slot edges. One case routes the last input channel to output channel 0 and the first input channel to output channel 31. A switch without a bank swap would emit stale or half-updated bytes there, and one that read its bank late would lose the channel 31 byte written on the wrap edge. A broadcast entry catches a design that serves only one reader per slot. A bit-order slip or a sampling point on the wrong cycle would shift or mirror every captured byte. A mid-frame pulse followed by full frames exposes a counter that ignores realignment or fails to swap banks on the pulse.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int DEF_LINES  = 8;
  localparam int DEF_CHANS  = 32;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_HADDR_W = 6;
  localparam int DEF_HDATA_W = 8;

  // Position of a cycle inside the frame: channel, bit, half-bit.
  function automatic int frame_cycles(input int chans, input int byte_w);
    return chans * byte_w * 2;
  endfunction
endpackage

// File: rtl/tsi_frame_ctr.sv
module tsi_frame_ctr #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frm_pulse,
  output logic [CNT_W-1:0] cnt,
  output logic             synced,
  output logic             wbank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      synced <= 1'b0;
      wbank  <= 1'b0;
    end else if (frm_pulse) begin
      cnt    <= '0;
      synced <= 1'b1;
      wbank  <= ~wbank;
    end else if (synced) begin
      cnt <= cnt + 1'b1;
      if (cnt == '1) wbank <= ~wbank;
    end
  end

  a_r2_idle_until_pulse: assert property (@(posedge clk) disable iff (rst)
    !synced |-> cnt == '0);
  a_r3_pulse_restarts: assert property (@(posedge clk) disable iff (rst)
    frm_pulse |=> (cnt == '0 && synced));
  a_r10_pulse_swaps_bank: assert property (@(posedge clk) disable iff (rst)
    frm_pulse |=> wbank != $past(wbank));
  a_r3_wrap_swaps_bank: assert property (@(posedge clk) disable iff (rst)
    (synced && !frm_pulse && cnt == '1) |=> (cnt == '0 && wbank != $past(wbank)));
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int LINES   = 8,
  parameter int CHANS   = 32,
  parameter int HADDR_W = 6,
  parameter int HDATA_W = 8,
  localparam int LINE_W = $clog2(LINES),
  localparam int CH_W   = $clog2(CHANS),
  localparam int SLOT_W = LINE_W + CH_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_we,
  input  logic [HADDR_W-1:0]           host_addr,
  input  logic [HDATA_W-1:0]           host_wdata,
  output logic [HDATA_W-1:0]           host_rdata,
  input  logic [CH_W-1:0]              rd_ch,
  output logic [LINES-1:0][SLOT_W-1:0] src_slot
);
  localparam int ENTRIES = LINES * CHANS;

  logic [LINE_W-1:0] page;
  logic [SLOT_W-1:0] cmem [ENTRIES];
  logic              ctl_sel;
  logic [SLOT_W-1:0] hidx;

  assign ctl_sel = host_addr[HADDR_W-1];
  assign hidx    = {page, host_addr[CH_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      for (int i = 0; i < ENTRIES; i++) cmem[i] <= '0;
    end else if (host_we) begin
      if (ctl_sel) page <= host_wdata[LINE_W-1:0];
      else         cmem[hidx] <= host_wdata[SLOT_W-1:0];
    end
  end

  assign host_rdata = ctl_sel ? HDATA_W'(page) : HDATA_W'(cmem[hidx]);

  always_comb begin
    for (int l = 0; l < LINES; l++) src_slot[l] = cmem[{LINE_W'(l), rd_ch}];
  end

  a_r7_entry_written: assert property (@(posedge clk) disable iff (rst)
    (host_we && !ctl_sel) |=> cmem[$past(hidx)] == $past(host_wdata[SLOT_W-1:0]));
  a_r7_page_holds: assert property (@(posedge clk) disable iff (rst)
    !host_we |=> $stable(page));
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int LINES  = 8,
  parameter int CHANS  = 32,
  parameter int BYTE_W = 8,
  localparam int LINE_W = $clog2(LINES),
  localparam int CH_W   = $clog2(CHANS),
  localparam int BIT_W  = $clog2(BYTE_W),
  localparam int SLOT_W = LINE_W + CH_W,
  localparam int CNT_W  = CH_W + BIT_W + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         synced,
  input  logic [CNT_W-1:0]             cnt,
  input  logic                         wbank,
  input  logic [LINES-1:0]             rx_ser,
  input  logic [LINES-1:0][SLOT_W-1:0] rd_slot,
  output logic [LINES-1:0][BYTE_W-1:0] rd_byte
);
  localparam int DEPTH = 2 * LINES * CHANS;

  logic [BYTE_W-1:0]             mem [DEPTH];
  logic [LINES-1:0][BYTE_W-1:0]  sr;
  logic                          sample_now;
  logic                          byte_done;
  logic [CH_W-1:0]               ch;

  assign sample_now = synced && cnt[0];
  assign byte_done  = synced && (cnt[BIT_W:0] == '1);
  assign ch         = cnt[CNT_W-1 -: CH_W];

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (sample_now) begin
      for (int l = 0; l < LINES; l++) sr[l] <= {sr[l][BYTE_W-2:0], rx_ser[l]};
    end
  end

  always_ff @(posedge clk) begin
    if (byte_done) begin
      for (int l = 0; l < LINES; l++)
        mem[{wbank, LINE_W'(l), ch}] <= {sr[l][BYTE_W-2:0], rx_ser[l]};
    end
  end

  always_comb begin
    for (int l = 0; l < LINES; l++) rd_byte[l] = mem[{~wbank, rd_slot[l]}];
  end

  a_r4_byte_lands: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> mem[{$past(wbank), {LINE_W{1'b0}}, $past(ch)}]
                  == $past({sr[0][BYTE_W-2:0], rx_ser[0]}));
  a_r4_shift_only_on_sample: assert property (@(posedge clk) disable iff (rst)
    !sample_now |=> $stable(sr));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int LINES   = tsi_pkg::DEF_LINES,
  parameter int CHANS   = tsi_pkg::DEF_CHANS,
  parameter int BYTE_W  = tsi_pkg::DEF_BYTE_W,
  parameter int HADDR_W = tsi_pkg::DEF_HADDR_W,
  parameter int HDATA_W = tsi_pkg::DEF_HDATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_pulse,
  input  logic               ode,
  input  logic [LINES-1:0]   rx_ser,
  output logic [LINES-1:0]   tx_ser,
  output logic               tx_drv,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  output logic [HDATA_W-1:0] host_rdata
);
  localparam int LINE_W = $clog2(LINES);
  localparam int CH_W   = $clog2(CHANS);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int SLOT_W = LINE_W + CH_W;
  localparam int CNT_W  = CH_W + BIT_W + 1;

  logic [CNT_W-1:0]             cnt;
  logic                         synced;
  logic                         wbank;
  logic [LINES-1:0][SLOT_W-1:0] src_slot;
  logic [LINES-1:0][BYTE_W-1:0] src_byte;
  logic [BIT_W-1:0]             bit_sel;

  tsi_frame_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .frm_pulse(frm_pulse),
    .cnt(cnt), .synced(synced), .wbank(wbank)
  );

  tsi_conn_mem #(.LINES(LINES), .CHANS(CHANS), .HADDR_W(HADDR_W), .HDATA_W(HDATA_W)) u_cmem (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rd_ch(cnt[CNT_W-1 -: CH_W]), .src_slot(src_slot)
  );

  tsi_data_mem #(.LINES(LINES), .CHANS(CHANS), .BYTE_W(BYTE_W)) u_dmem (
    .clk(clk), .rst(rst), .synced(synced), .cnt(cnt), .wbank(wbank),
    .rx_ser(rx_ser), .rd_slot(src_slot), .rd_byte(src_byte)
  );

  assign bit_sel = cnt[BIT_W:1];
  assign tx_drv  = ode & synced;

  for (genvar l = 0; l < LINES; l++) begin : g_tx
    assign tx_ser[l] = tx_drv & src_byte[l][~bit_sel];
  end

  a_r2_quiet_before_pulse: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !tx_drv);
  a_r8_disable_silences: assert property (@(posedge clk) disable iff (rst)
    !ode |-> (!tx_drv && tx_ser == '0));
endmodule

// File: tb/sim_tsi_switch.sv
`timescale 1ns/1ps
module sim_tsi_switch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_pulse = 1'b0;
  logic       ode = 1'b1;
  logic [7:0] rx_ser = '0;
  logic [7:0] tx_ser;
  logic       tx_drv;
  logic       host_we = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] cap [8][32];

  // {out line, out channel, source line, source channel}
  localparam logic [15:0] VEC [8] = '{
    {3'd0, 5'd0,  3'd7, 5'd31},
    {3'd7, 5'd31, 3'd0, 5'd0},
    {3'd3, 5'd10, 3'd3, 5'd10},
    {3'd1, 5'd5,  3'd6, 5'd20},
    {3'd2, 5'd5,  3'd6, 5'd20},
    {3'd5, 5'd17, 3'd2, 5'd3},
    {3'd6, 5'd0,  3'd6, 5'd31},
    {3'd4, 5'd31, 3'd4, 5'd0}
  };

  tsi_switch u0 (
    .clk(clk), .rst(rst), .frm_pulse(frm_pulse), .ode(ode), .rx_ser(rx_ser),
    .tx_ser(tx_ser), .tx_drv(tx_drv), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input int f, input int s, input int c);
    return 8'(s * 37 + c * 11 + f * 73 + 5);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [5:0] a, input logic [7:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input logic [5:0] a, output logic [7:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  // Entered at a falling edge where the counter holds position 0.
  task automatic run_frame(input int f, input int len, input int pulse_at, input bit off);
    for (int k = 0; k < len; k++) begin
      for (int s = 0; s < 8; s++) rx_ser[s] = pat(f, s, k / 16)[7 - (k / 2) % 8];
      ode = !(off && k >= 32 && k < 64);
      frm_pulse = (k == pulse_at);
      #1;
      if (k % 2 == 1)
        for (int p = 0; p < 8; p++) cap[p][k / 16][7 - (k / 2) % 8] = tx_ser[p];
      if (off && k == 40) begin
        chk("R8 drive off", {31'b0, tx_drv}, 32'd0);
        chk("R8 data zero", {24'b0, tx_ser}, 32'd0);
      end
      if (off && k == 70) chk("R8 resumed", {31'b0, tx_drv}, 32'd1);
      @(negedge clk);
    end
    frm_pulse = 1'b0;
  endtask

  task automatic compare(input int f, input string req);
    for (int i = 0; i < 8; i++)
      chk(i == 4 ? "R9 broadcast" : req,
          {24'b0, cap[VEC[i][15:13]][VEC[i][12:8]]},
          {24'b0, pat(f, int'(VEC[i][7:5]), int'(VEC[i][4:0]))});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 drive", {31'b0, tx_drv}, 32'd0);
    chk("R1 data", {24'b0, tx_ser}, 32'd0);
    host_read(6'h20, rd); chk("R1 page", {24'b0, rd}, 32'd0);
    host_read(6'h00, rd); chk("R1 entry0", {24'b0, rd}, 32'd0);
    host_read(6'h1F, rd); chk("R1 entry31", {24'b0, rd}, 32'd0);
    // R2 no drive before the first pulse
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk); #1;
        if (tx_drv) seen = 1'b1;
      end
      chk("R2 quiet before pulse", {31'b0, seen}, 32'd0);
    end
    @(negedge clk);
    // R7 program and read back the table
    for (int i = 0; i < 8; i++) begin
      host_write(6'h20, {5'b0, VEC[i][15:13]});
      host_write({1'b0, VEC[i][12:8]}, VEC[i][7:0]);
    end
    for (int i = 0; i < 8; i++) begin
      host_write(6'h20, {5'b0, VEC[i][15:13]});
      host_read(6'h20, rd); chk("R7 page readback", {24'b0, rd}, {29'b0, VEC[i][15:13]});
      host_read({1'b0, VEC[i][12:8]}, rd); chk("R7 entry readback", {24'b0, rd}, {24'b0, VEC[i][7:0]});
    end
    @(negedge clk);
    frm_pulse = 1'b1;
    @(negedge clk);
    frm_pulse = 1'b0;
    #1 chk("R3 drive after pulse", {31'b0, tx_drv}, 32'd1);
    run_frame(0, 512, -1, 1'b0);
    run_frame(1, 512, -1, 1'b0);
    compare(0, "R4/R6 routed byte");
    run_frame(2, 512, -1, 1'b0);
    compare(1, "R3/R5 next frame byte");
    run_frame(3, 101, 100, 1'b1);
    run_frame(4, 512, -1, 1'b0);
    run_frame(5, 512, -1, 1'b0);
    compare(4, "R10 realigned byte");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule